// File: doc/BRIEF.md
# Audio User-Bit Block Capture

This block gathers the user-data bit that rides in every audio subframe of an IEC 60958 style stream. It collects one bit per frame over a 192-frame block and exposes the finished set as a 192-bit register. An upstream decoder delivers one strobe per subframe. Each strobe carries the user bit, a flag that says whether it belongs to the first or the second subframe of its frame, and a marker that is set on frame 0, where a new block begins.

A select input picks which subframe supplies the bits. The block latches the select at each block boundary, so one block never mixes bits from both subframes. Bits build up in a shadow shift register. When the next frame-0 marker arrives and exactly 192 bits have been gathered, the whole shadow is copied into the visible register in one cycle and a one-cycle done pulse is raised. Readers therefore always see a complete previous block. If a block arrives with too few or too many bits, it is dropped and a sticky error flag is raised.

Top module: `user_bit_capture`

## Requirements
- R1: During and immediately after a synchronous reset, `user_bits` is all zero and both `blk_done` and `seq_err` are low.
- R2: Bit k of `user_bits` holds the user bit of frame k (frame 0 at index 0) of the previous complete block. It is taken from the subframe selected for that block. `user_bits` changes one clock after the boundary strobe and at no other time.
- R3: `blk_done` is high for exactly one cycle: the cycle in which `user_bits` has just been refreshed.
- R4: A boundary strobe has `sf_valid`=1, `sf_blkstart`=1 and `sf_second`=0. `sf_second`=0 marks the first subframe and 1 marks the second. `sel_second`=0 gathers first-subframe bits and 1 gathers second-subframe bits.
- R5: `sel_second` is sampled only on a boundary strobe. A change in the middle of a block does not affect the block being gathered.
- R6: A boundary that follows a block with fewer than 192 selected bits causes no publish and no done pulse, and leaves `user_bits` unchanged. It sets `seq_err`, which stays high until reset.
- R7: A boundary that follows a block with more than 192 selected bits is treated in the same way as in R6.
- R8: Strobes before the first boundary after reset are ignored. The first boundary neither publishes nor sets `seq_err`.
- R9: Cycles with `sf_valid`=0 have no effect. A `sf_blkstart` marker on a second-subframe strobe does not start a block: that strobe is handled as a normal bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sf_valid | input | 1 | One-cycle subframe strobe |
| sf_user | input | 1 | User-data bit of this subframe |
| sf_second | input | 1 | 0 = first subframe, 1 = second subframe |
| sf_blkstart | input | 1 | Frame-0 marker |
| sel_second | input | 1 | Subframe select, latched at each boundary |
| user_bits | output | 192 | Visible user-data set of the previous block |
| blk_done | output | 1 | Pulse on each refresh of `user_bits` |
| seq_err | output | 1 | Sticky bad-block-length flag |

## Verification
The key coincidence is on the boundary strobe. In one cycle it publishes the old shadow, and when the first subframe is selected it also shifts in bit 0 of the new block. The same strobe can instead flag an error while restarting the count. The bench drives selected-first-subframe blocks back to back, with idle cycles placed at random. It compares `user_bits` against a pattern function of the previous block, to confirm that the publish saw the old shadow and that the new frame-0 bit landed in the next block. Short and long blocks are placed just before boundaries to check that the error path neither publishes nor loses the restart.

// File: rtl/ubc_pkg.sv
package ubc_pkg;
  typedef enum logic {
    SUB_FIRST  = 1'b0,
    SUB_SECOND = 1'b1
  } sub_e;
endpackage

// File: rtl/ubc_frame_ctl.sv
module ubc_frame_ctl
  import ubc_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic strobe,
  input  logic is_second,
  input  logic blk_mark,
  input  logic sel_in,
  output logic boundary,
  output logic capture,
  output logic synced
);
  sub_e act_sel;
  sub_e sel_now;
  logic sync_now;

  always_comb begin
    boundary = strobe & blk_mark & ~is_second;
    sel_now  = boundary ? sub_e'(sel_in) : act_sel;
    sync_now = synced | boundary;
    capture  = strobe & sync_now & (sub_e'(is_second) == sel_now);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      act_sel <= SUB_FIRST;
      synced  <= 1'b0;
    end else if (boundary) begin
      act_sel <= sub_e'(sel_in);
      synced  <= 1'b1;
    end
  end
endmodule

// File: rtl/ubc_shadow.sv
module ubc_shadow #(
  parameter int BLOCK_LEN = 192,
  parameter int CNT_W     = $clog2(BLOCK_LEN + 2)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 boundary,
  input  logic                 capture,
  input  logic                 bit_in,
  output logic [BLOCK_LEN-1:0] shadow,
  output logic [CNT_W-1:0]     count
);
  localparam logic [CNT_W-1:0] SAT = CNT_W'(BLOCK_LEN + 1);

  always_ff @(posedge clk) begin
    if (rst) begin
      count  <= '0;
      shadow <= '0;
    end else begin
      if (boundary)
        count <= {{(CNT_W-1){1'b0}}, capture};
      else if (capture && count != SAT)
        count <= count + 1'b1;
      if (capture)
        shadow <= {bit_in, shadow[BLOCK_LEN-1:1]};
    end
  end
endmodule

// File: rtl/ubc_publish.sv
module ubc_publish #(
  parameter int BLOCK_LEN = 192,
  parameter int CNT_W     = $clog2(BLOCK_LEN + 2)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 boundary,
  input  logic                 synced,
  input  logic [CNT_W-1:0]     count,
  input  logic [BLOCK_LEN-1:0] shadow,
  output logic [BLOCK_LEN-1:0] user_bits,
  output logic                 blk_done,
  output logic                 seq_err
);
  localparam logic [CNT_W-1:0] FULL = CNT_W'(BLOCK_LEN);
  logic full;

  assign full = (count == FULL);

  always_ff @(posedge clk) begin
    if (rst) begin
      user_bits <= '0;
      blk_done  <= 1'b0;
      seq_err   <= 1'b0;
    end else begin
      blk_done <= 1'b0;
      if (boundary && synced) begin
        if (full) begin
          user_bits <= shadow;
          blk_done  <= 1'b1;
        end else begin
          seq_err <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/user_bit_capture.sv
module user_bit_capture #(
  parameter int BLOCK_LEN = 192
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 sf_valid,
  input  logic                 sf_user,
  input  logic                 sf_second,
  input  logic                 sf_blkstart,
  input  logic                 sel_second,
  output logic [BLOCK_LEN-1:0] user_bits,
  output logic                 blk_done,
  output logic                 seq_err
);
  localparam int CNT_W = $clog2(BLOCK_LEN + 2);

  logic                 boundary;
  logic                 capture;
  logic                 synced;
  logic [BLOCK_LEN-1:0] shadow;
  logic [CNT_W-1:0]     count;

  ubc_frame_ctl u_ctl (
    .clk       (clk),
    .rst       (rst),
    .strobe    (sf_valid),
    .is_second (sf_second),
    .blk_mark  (sf_blkstart),
    .sel_in    (sel_second),
    .boundary  (boundary),
    .capture   (capture),
    .synced    (synced)
  );

  ubc_shadow #(.BLOCK_LEN(BLOCK_LEN), .CNT_W(CNT_W)) u_shadow (
    .clk      (clk),
    .rst      (rst),
    .boundary (boundary),
    .capture  (capture),
    .bit_in   (sf_user),
    .shadow   (shadow),
    .count    (count)
  );

  ubc_publish #(.BLOCK_LEN(BLOCK_LEN), .CNT_W(CNT_W)) u_pub (
    .clk       (clk),
    .rst       (rst),
    .boundary  (boundary),
    .synced    (synced),
    .count     (count),
    .shadow    (shadow),
    .user_bits (user_bits),
    .blk_done  (blk_done),
    .seq_err   (seq_err)
  );
endmodule

// File: rtl/ubc_checker.sv
module ubc_checker #(
  parameter int BLOCK_LEN = 192
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 sf_valid,
  input logic                 sf_second,
  input logic                 sf_blkstart,
  input logic [BLOCK_LEN-1:0] user_bits,
  input logic                 blk_done,
  input logic                 seq_err
);
  logic past_ok;

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst || !past_ok)
    blk_done |=> !blk_done); // R3

  AST_DONE_AFTER_BOUNDARY: assert property (@(posedge clk) disable iff (rst || !past_ok)
    blk_done |-> $past(sf_valid && sf_blkstart && !sf_second)); // R2

  AST_BITS_HELD: assert property (@(posedge clk) disable iff (rst || !past_ok)
    !blk_done |-> $stable(user_bits)); // R2

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst || !past_ok)
    seq_err |=> seq_err); // R6

  AST_ERR_NO_PUBLISH: assert property (@(posedge clk) disable iff (rst || !past_ok)
    $rose(seq_err) |-> !blk_done); // R6
endmodule

bind user_bit_capture ubc_checker #(.BLOCK_LEN(BLOCK_LEN)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .sf_valid    (sf_valid),
  .sf_second   (sf_second),
  .sf_blkstart (sf_blkstart),
  .user_bits   (user_bits),
  .blk_done    (blk_done),
  .seq_err     (seq_err)
);

// File: tb/user_bit_capture_tb.sv
module user_bit_capture_tb;
  localparam int N = 192;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         sf_valid = 1'b0;
  logic         sf_user = 1'b0;
  logic         sf_second = 1'b0;
  logic         sf_blkstart = 1'b0;
  logic         sel_second = 1'b0;
  logic [N-1:0] user_bits;
  logic         blk_done;
  logic         seq_err;

  int checks = 0;
  int errors = 0;
  bit ended = 1'b0;

  // reference model state
  logic [N-1:0] m_shadow = '0;
  logic [N-1:0] e_bits = '0;
  bit           e_done = 1'b0;
  bit           e_err = 1'b0;
  bit           m_sync = 1'b0;
  bit           m_sel = 1'b0;
  int           m_cnt = 0;

  always #2 clk = ~clk;

  user_bit_capture #(.BLOCK_LEN(N)) u_dut (
    .clk(clk), .rst(rst), .sf_valid(sf_valid), .sf_user(sf_user),
    .sf_second(sf_second), .sf_blkstart(sf_blkstart), .sel_second(sel_second),
    .user_bits(user_bits), .blk_done(blk_done), .seq_err(seq_err)
  );

  function automatic bit pat_first(int k);
    return (k % 5) == 1;
  endfunction

  function automatic bit pat_second(int k);
    return (k % 7) == 0 || k == N - 1;
  endfunction

  function automatic logic [N-1:0] pat_vec(bit second);
    logic [N-1:0] v;
    for (int k = 0; k < N; k++) v[k] = second ? pat_second(k) : pat_first(k);
    return v;
  endfunction

  task automatic chk(bit ok, string tag, string what, logic [N-1:0] act, logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic model(bit v, bit u, bit sec, bit st, bit sel);
    bit bnd;
    bnd = v && st && !sec;
    e_done = 1'b0;
    if (bnd) begin
      if (m_sync && m_cnt == N) begin
        e_bits = m_shadow;
        e_done = 1'b1;
      end else if (m_sync) begin
        e_err = 1'b1;
      end
      m_sync = 1'b1;
      m_sel = sel;
      m_cnt = 0;
    end
    if (v && m_sync && sec == m_sel) begin
      m_shadow = {u, m_shadow[N-1:1]};
      if (m_cnt < N + 1) m_cnt++;
    end
  endtask

  // called at a negedge; leaves at the following negedge
  task automatic step(bit v, bit u, bit sec, bit st, string tag);
    sf_valid = v; sf_user = u; sf_second = sec; sf_blkstart = st;
    @(posedge clk);
    model(v, u, sec, st, sel_second);
    @(negedge clk);
    chk(blk_done === e_done, tag, "blk_done", N'(blk_done), N'(e_done));
    chk(user_bits === e_bits, tag, "user_bits", user_bits, e_bits);
    chk(seq_err === e_err, tag, "seq_err", N'(seq_err), N'(e_err));
    sf_valid = 1'b0;
  endtask

  task automatic idle_gap(string tag);
    if (($urandom % 4) == 0)
      step(1'b0, 1'($urandom), 1'($urandom), 1'($urandom), tag); // R9 junk while invalid
  endtask

  task automatic frame(int f, bit u1, bit u2, bit mark, string tag);
    step(1'b1, u1, 1'b0, mark && f == 0, tag);
    idle_gap(tag);
    step(1'b1, u2, 1'b1, mark && f == 0, tag);
    idle_gap(tag);
  endtask

  task automatic rand_frames(int from, int to, string tag);
    for (int f = from; f < to; f++) frame(f, 1'($urandom), 1'($urandom), 1'b1, tag);
  endtask

  initial begin
    void'($urandom(32'h5eed_0042));
    repeat (3) @(negedge clk);
    // R1: outputs during reset
    chk(user_bits === '0, "R1", "user_bits in reset", user_bits, '0);
    chk(blk_done === 1'b0 && seq_err === 1'b0, "R1", "flags in reset",
        N'({blk_done, seq_err}), '0);
    rst = 1'b0;
    @(negedge clk);
    chk(user_bits === '0 && blk_done === 1'b0 && seq_err === 1'b0, "R1",
        "outputs after reset", user_bits, '0);

    // R8: unsynchronised strobes ignored, first boundary silent
    for (int i = 0; i < 12; i++) step(1'b1, 1'b1, 1'(i), 1'b0, "R8");
    sel_second = 1'b0;
    frame(0, pat_first(0), pat_second(0), 1'b1, "R8");
    chk(blk_done === 1'b0 && seq_err === 1'b0, "R8", "first boundary flags",
        N'({blk_done, seq_err}), '0);
    for (int f = 1; f < N; f++) frame(f, pat_first(f), pat_second(f), 1'b1, "R4");

    // R2/R4: next block gathers second subframe; publish of first-subframe pattern
    sel_second = 1'b1;
    frame(0, pat_first(0), pat_second(0), 1'b1, "R2");
    chk(user_bits === pat_vec(1'b0), "R2", "first-subframe set", user_bits, pat_vec(1'b0));
    for (int f = 1; f < N; f++) begin
      if (f == 60) sel_second = 1'b0; // R5: mid-block change has no effect
      frame(f, pat_first(f), pat_second(f), 1'b1, "R5");
    end
    sel_second = 1'b0;
    frame(0, 1'b1, 1'b0, 1'b1, "R5");
    chk(user_bits === pat_vec(1'b1), "R5", "second-subframe set kept", user_bits, pat_vec(1'b1));
    chk(user_bits[0] === 1'b1 && user_bits[N-1] === 1'b1, "R4", "index ends",
        N'(user_bits[0]), N'(1));

    // random blocks with random select
    for (int b = 0; b < 5; b++) begin
      rand_frames(1, N, "R2");
      sel_second = 1'($urandom);
      frame(0, 1'($urandom), 1'($urandom), 1'b1, "R3");
    end

    // R9: marker on second subframe mid-block is a plain bit
    for (int f = 1; f < N; f++) begin
      if (f == 77) begin
        step(1'b1, 1'b1, 1'b0, 1'b0, "R9");
        step(1'b1, 1'b0, 1'b1, 1'b1, "R9");
      end else begin
        frame(f, 1'($urandom), 1'($urandom), 1'b1, "R9");
      end
    end
    frame(0, 1'b0, 1'b1, 1'b1, "R9");
    chk(seq_err === 1'b0, "R9", "no error from second-subframe marker", N'(seq_err), '0);

    // R6: short block
    rand_frames(1, 100, "R6");
    frame(0, 1'b1, 1'b1, 1'b1, "R6");
    chk(seq_err === 1'b1, "R6", "short block flagged", N'(seq_err), N'(1));
    rand_frames(1, N, "R6");
    frame(0, 1'b0, 1'b0, 1'b1, "R6");
    chk(seq_err === 1'b1, "R6", "flag sticky after good block", N'(seq_err), N'(1));

    // R7: long block
    rand_frames(1, N + 3, "R7");
    frame(0, 1'b1, 1'b0, 1'b1, "R7");
    rand_frames(1, N, "R7");
    frame(0, 1'b1, 1'b0, 1'b1, "R7");
    rand_frames(1, 20, "R7");

    ended = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!ended) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule